// File: doc/BRIEF.md
# Page Table Entry Cache

This block keeps recently fetched 32-bit page-directory and page-table words close to a translation walker. The walker presents a word address. When the cache holds that word, it answers from its line store without touching memory. When it does not, the block issues a read on its memory port, writes the returned word into the line the address maps to, and passes the word back to the walker. Memory replies return in the order the reads were issued. Responses to the walker also come back in request order.

Software-visible control comes in as three write strobes. A configuration word carries the enable, the read limit and an index mask. A flush word either clears the whole cache or clears the lines inside one memory atom. A 2-bit high-address word supplies physical address bits 33:32 for a flush by address. The cache is direct mapped with one word per line. The physical address is 34 bits wide, so a word address is 32 bits (physical bits 33:2).

Top module: `ptcCache`

## Requirements
- R1: After reset no response and no memory read is signalled. The configuration reads back as enable 0, read limit 8 and index mask 0x3f, so the first requests go to memory.
- R2: With the enable set, a request that finds a valid line holding its address is accepted in the same cycle without a memory read. `rspValid` rises on the next cycle with the stored word.
- R3: A request that misses is accepted in the same cycle as `memReqValid` with `memReqAddr` equal to `reqAddr`. A reply on `memRspValid` in cycle t gives `rspValid` and the returned word in cycle t+1, and the line is filled so that a later request for the same address hits.
- R4: With the enable clear, every accepted request issues a memory read and no line is filled. After the enable is set again, the same address still misses.
- R5: A flush write with bit 0 clear invalidates every line.
- R6: A flush write with bit 0 set forms the physical address {high register, flush word} and aligns it down to the 32-byte atom. It invalidates only lines whose word lies in that atom; other lines stay valid.
- R7: Flush-by-address matching uses the 2-bit high register as physical bits 33:32. A flush whose high bits differ from a line's leaves that line valid.
- R8: In the configuration word, bit 29 is the enable, bits 27:24 are the read limit and bits 5:0 are the index mask.
- R9: A miss is accepted only while fewer reads are outstanding than the limit, with a limit of 0 taken as 1. Otherwise `reqReady` stays low.
- R10: A flush that matches a read still pending lets its reply through to the walker but leaves no valid line behind. This also holds when the flush coincides with the reply or with the issue of the read.
- R11: A request that would hit is held (`reqReady` low) while any read is outstanding. Every response appears in request order.
- R12: The line index is word-address bits 3:0 ANDed with index-mask bits 3:0. With a mask of 0, all addresses share line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWe | input | 1 | Configuration write strobe |
| cfgWdata | input | 32 | Configuration word |
| flushHiWe | input | 1 | High flush-address write strobe |
| flushHiWdata | input | 2 | Physical address bits 33:32 for flush matching |
| flushWe | input | 1 | Flush command strobe |
| flushWdata | input | 32 | Flush word: bit 0 type, upper bits low physical address |
| reqValid | input | 1 | Walker request valid |
| reqAddr | input | 32 | Requested word address |
| reqReady | output | 1 | Request accepted this cycle |
| rspValid | output | 1 | Response valid |
| rspData | output | 32 | Returned table word |
| memReqValid | output | 1 | Memory read issued |
| memReqAddr | output | 32 | Memory read word address |
| memRspValid | input | 1 | Memory reply valid (in issue order) |
| memRspData | input | 32 | Memory reply word |

## Verification
The bench targets flushes that land on a read still in flight. This includes a flush in the same cycle as the reply. A design that marks the line valid anyway would turn the next request into a wrong hit, which skips the expected memory read. Flushes whose high bits or atom offset differ from a line's are mixed with matching ones. Too wide a match would cause extra misses, and too narrow a match would cause stale hits. Hits issued behind outstanding misses, limit changes down to zero, and index masks that force aliasing are also driven. Any reordering, over-issue or wrong line selection then shows up as a response word or a `reqReady` value that differs from the reference model.

// File: rtl/ptcPkg.sv
package ptcPkg;
  localparam int WORD_W = 32;
  localparam int PA_W = 34;
  localparam int HI_W = PA_W - WORD_W;

  typedef struct packed {
    logic hitAccept;
    logic pushMiss;
    logic pushSkip;
    logic popFill;
    logic flushAll;
    logic flushOne;
  } ptcStrobeT;
endpackage

// File: rtl/ptcDatapath.sv
module ptcDatapath
  import ptcPkg::*;
#(
  parameter int LINES = 16,
  parameter int DEPTH = 16,
  parameter int ATOM_BYTES = 32
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  ptcStrobeT                             strobe,
  input  logic [PA_W-$clog2(ATOM_BYTES)-1:0]    flushKey,
  input  logic [5:0]                            indexMap,
  input  logic [WORD_W-1:0]                     reqAddr,
  input  logic [WORD_W-1:0]                     memRspData,
  output logic                                  lookupHit,
  output logic                                  rspValid,
  output logic [WORD_W-1:0]                     rspData
);
  localparam int IDX_W = $clog2(LINES);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int WSH = $clog2(ATOM_BYTES) - 2;
  localparam int KEY_W = PA_W - $clog2(ATOM_BYTES);

  logic [LINES-1:0]  lineValid;
  logic [WORD_W-1:0] lineAddr [LINES];
  logic [WORD_W-1:0] lineData [LINES];
  logic [WORD_W-1:0] pendAddr [DEPTH];
  logic [DEPTH-1:0]  pendSkip;
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [PTR_W:0]    pendCnt;
  logic [IDX_W-1:0]  lkIdx, fillIdx;
  logic [WORD_W-1:0] headAddr;
  logic              doFill;

  function automatic logic [IDX_W-1:0] lineIdx(input logic [WORD_W-1:0] a,
                                               input logic [5:0] m);
    return a[IDX_W-1:0] & m[IDX_W-1:0];
  endfunction

  function automatic logic flushHits(input logic [WORD_W-1:0] a,
                                     input ptcStrobeT s,
                                     input logic [KEY_W-1:0] k);
    return s.flushAll || (s.flushOne && (a[WORD_W-1:WSH] == k));
  endfunction

  always_comb begin
    lkIdx = lineIdx(reqAddr, indexMap);
    lookupHit = lineValid[lkIdx] && (lineAddr[lkIdx] == reqAddr);
    headAddr = pendAddr[rdPtr];
    fillIdx = lineIdx(headAddr, indexMap);
    doFill = strobe.popFill && !pendSkip[rdPtr] && !flushHits(headAddr, strobe, flushKey);
  end

  // line valid bits: a fill wins over a flush of the old occupant
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineValid <= '0;
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (doFill && fillIdx == IDX_W'(i)) lineValid[i] <= 1'b1;
        else if (flushHits(lineAddr[i], strobe, flushKey)) lineValid[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (doFill) begin
      lineAddr[fillIdx] <= headAddr;
      lineData[fillIdx] <= memRspData;
    end
    if (strobe.pushMiss) pendAddr[wrPtr] <= reqAddr;
  end

  // pending reads, in issue order; DEPTH must be a power of two
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      pendCnt <= '0;
      pendSkip <= '0;
    end else begin
      for (int j = 0; j < DEPTH; j++)
        if (flushHits(pendAddr[j], strobe, flushKey)) pendSkip[j] <= 1'b1;
      if (strobe.pushMiss) begin
        pendSkip[wrPtr] <= strobe.pushSkip || flushHits(reqAddr, strobe, flushKey);
        wrPtr <= wrPtr + 1'b1;
      end
      if (strobe.popFill) rdPtr <= rdPtr + 1'b1;
      pendCnt <= pendCnt + (PTR_W+1)'(strobe.pushMiss) - (PTR_W+1)'(strobe.popFill);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspData <= '0;
    end else begin
      rspValid <= strobe.hitAccept || strobe.popFill;
      rspData <= strobe.popFill ? memRspData : lineData[lkIdx];
    end
  end

  assert_flush_all_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flushAll |=> (lineValid == '0));
  assert_skip_no_fill_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.popFill && pendSkip[rdPtr]) |=> ((lineValid & ~$past(lineValid)) == '0));
  assert_pop_nonempty_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.popFill |-> (pendCnt != '0));
  assert_rsp_exclusive_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.hitAccept && strobe.popFill));
  assert_fifo_room_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pushMiss |-> (pendCnt < (PTR_W+1)'(DEPTH)));
endmodule

// File: rtl/ptcControl.sv
module ptcControl
  import ptcPkg::*;
#(
  parameter int DEPTH = 16,
  parameter int ATOM_BYTES = 32
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               cfgWe,
  input  logic [WORD_W-1:0]                  cfgWdata,
  input  logic                               flushHiWe,
  input  logic [HI_W-1:0]                    flushHiWdata,
  input  logic                               flushWe,
  input  logic [WORD_W-1:0]                  flushWdata,
  input  logic                               reqValid,
  input  logic                               lookupHit,
  input  logic                               memRspValid,
  output logic                               reqReady,
  output logic                               memReqValid,
  output ptcStrobeT                          strobe,
  output logic [PA_W-$clog2(ATOM_BYTES)-1:0] flushKey,
  output logic [5:0]                         indexMap
);
  // DEPTH must be at least 16 so the count can reach the largest limit
  localparam int CNT_W = $clog2(DEPTH) + 1;
  localparam int ATOM_LSB = $clog2(ATOM_BYTES);
  localparam int EN_BIT = 29;
  localparam int LIM_LSB = 24;

  logic              cfgEnable;
  logic [3:0]        reqLimit;
  logic [HI_W-1:0]   flushHi;
  logic [CNT_W-1:0]  outCnt, effLimit;
  logic [PA_W-1:0]   flushPa;
  logic              cacheHit, hitAccept, missAccept;
  logic              unusedBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgEnable <= 1'b0;
      reqLimit <= 4'd8;
      indexMap <= 6'h3f;
      flushHi <= '0;
    end else begin
      if (cfgWe) begin
        cfgEnable <= cfgWdata[EN_BIT];
        reqLimit <= cfgWdata[LIM_LSB+3:LIM_LSB];
        indexMap <= cfgWdata[5:0];
      end
      if (flushHiWe) flushHi <= flushHiWdata;
    end
  end

  always_comb begin
    effLimit = (reqLimit == 4'd0) ? CNT_W'(1) : CNT_W'(reqLimit);
    cacheHit = cfgEnable && lookupHit;
    hitAccept = reqValid && cacheHit && (outCnt == '0);
    missAccept = reqValid && !cacheHit && (outCnt < effLimit);
    flushPa = {flushHi, flushWdata};
    flushKey = flushPa[PA_W-1:ATOM_LSB];
    strobe.hitAccept = hitAccept;
    strobe.pushMiss = missAccept;
    strobe.pushSkip = !cfgEnable;
    strobe.popFill = memRspValid;
    strobe.flushAll = flushWe && !flushPa[0];
    strobe.flushOne = flushWe && flushPa[0];
  end

  assign reqReady = hitAccept || missAccept;
  assign memReqValid = missAccept;
  assign unusedBits = ^{cfgWdata[31:30], cfgWdata[28], cfgWdata[23:6], flushPa[ATOM_LSB-1:1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outCnt <= '0;
    else outCnt <= outCnt + CNT_W'(missAccept) - CNT_W'(memRspValid);
  end

  assert_limit_R9: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> (outCnt <= $past(effLimit)));
  assert_bypass_R4: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && !cfgEnable) |-> memReqValid);
  assert_hit_order_R11: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && !memReqValid) |-> (outCnt == '0));
  assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWe |=> $stable(indexMap));
endmodule

// File: rtl/ptcCache.sv
module ptcCache
  import ptcPkg::*;
#(
  parameter int LINES = 16,
  parameter int DEPTH = 16,
  parameter int ATOM_BYTES = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWe,
  input  logic [31:0] cfgWdata,
  input  logic        flushHiWe,
  input  logic [1:0]  flushHiWdata,
  input  logic        flushWe,
  input  logic [31:0] flushWdata,
  input  logic        reqValid,
  input  logic [31:0] reqAddr,
  output logic        reqReady,
  output logic        rspValid,
  output logic [31:0] rspData,
  output logic        memReqValid,
  output logic [31:0] memReqAddr,
  input  logic        memRspValid,
  input  logic [31:0] memRspData
);
  localparam int KEY_W = PA_W - $clog2(ATOM_BYTES);

  ptcStrobeT        strobe;
  logic [KEY_W-1:0] flushKey;
  logic [5:0]       indexMap;
  logic             lookupHit;

  ptcControl #(.DEPTH(DEPTH), .ATOM_BYTES(ATOM_BYTES)) ctrl (
    .clk(clk), .rstN(rstN),
    .cfgWe(cfgWe), .cfgWdata(cfgWdata),
    .flushHiWe(flushHiWe), .flushHiWdata(flushHiWdata),
    .flushWe(flushWe), .flushWdata(flushWdata),
    .reqValid(reqValid), .lookupHit(lookupHit), .memRspValid(memRspValid),
    .reqReady(reqReady), .memReqValid(memReqValid),
    .strobe(strobe), .flushKey(flushKey), .indexMap(indexMap)
  );

  ptcDatapath #(.LINES(LINES), .DEPTH(DEPTH), .ATOM_BYTES(ATOM_BYTES)) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .flushKey(flushKey),
    .indexMap(indexMap), .reqAddr(reqAddr), .memRspData(memRspData),
    .lookupHit(lookupHit), .rspValid(rspValid), .rspData(rspData)
  );

  assign memReqAddr = reqAddr;
endmodule

// File: tb/ptcCache_test.sv
module ptcCache_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic        cfgWe = 0, flushHiWe = 0, flushWe = 0, reqValid = 0, memRspValid = 0;
  logic [31:0] cfgWdata = 0, flushWdata = 0, reqAddr = 0, memRspData = 0;
  logic [1:0]  flushHiWdata = 0;
  logic        reqReady, rspValid, memReqValid;
  logic [31:0] rspData, memReqAddr;

  ptcCache uut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWdata(cfgWdata),
    .flushHiWe(flushHiWe), .flushHiWdata(flushHiWdata),
    .flushWe(flushWe), .flushWdata(flushWdata),
    .reqValid(reqValid), .reqAddr(reqAddr), .reqReady(reqReady),
    .rspValid(rspValid), .rspData(rspData),
    .memReqValid(memReqValid), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData)
  );

  int checks = 0, errors = 0, cyc = 0, latMin = 1, latMax = 1;
  bit done = 0;
  // stimulus for the next cycle
  logic        sReq = 0, sCfgWe = 0, sFlWe = 0, sHiWe = 0;
  logic [31:0] sAddr = 0, sCfg = 0, sFl = 0;
  logic [1:0]  sHi = 0;
  logic        lastReady, lastMiss;
  // reference model state
  logic        mEn = 0;
  int          mLimit = 8;
  logic [5:0]  mMap = 6'h3f;
  logic [1:0]  mHi = 0;
  logic        mValid [16];
  logic [31:0] mAddr [16];
  logic [31:0] pendQ [$];
  bit          skipQ [$];
  int          dueQ [$];
  logic [31:0] expQ [$];

  function automatic logic [31:0] memWord(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5AC3C3;
  endfunction

  function automatic logic [31:0] cfgWord(input logic en, input logic [3:0] lim, input logic [5:0] map);
    return {2'b00, en, 1'b0, lim, 18'd0, map};
  endfunction

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic applyFlush(input logic [31:0] fw);
    logic [33:0] pa;
    pa = {mHi, fw};
    if (!fw[0]) begin
      for (int i = 0; i < 16; i++) mValid[i] = 0;
      for (int j = 0; j < skipQ.size(); j++) skipQ[j] = 1;
    end else begin
      for (int i = 0; i < 16; i++) if (mAddr[i][31:3] == pa[33:5]) mValid[i] = 0;
      for (int j = 0; j < pendQ.size(); j++) if (pendQ[j][31:3] == pa[33:5]) skipQ[j] = 1;
    end
  endtask

  task automatic step();
    logic [3:0] idx;
    logic hit, expReady;
    int effL, outN;
    @(negedge clk);
    cyc++;
    if (rspValid) begin
      if (expQ.size() == 0) check(1'b0, "R11 response with none pending", rspData, 0);
      else begin
        check(rspData == expQ[0], "R3 R11 response word in order", rspData, expQ[0]);
        void'(expQ.pop_front());
      end
    end
    memRspValid = 0;
    memRspData = 0;
    if (pendQ.size() != 0 && dueQ[0] <= cyc) begin
      memRspValid = 1;
      memRspData = memWord(pendQ[0]);
    end
    reqValid = sReq; reqAddr = sAddr;
    cfgWe = sCfgWe; cfgWdata = sCfg;
    flushWe = sFlWe; flushWdata = sFl;
    flushHiWe = sHiWe; flushHiWdata = sHi;
    #5;
    outN = pendQ.size();
    lastReady = 0;
    lastMiss = 0;
    if (sReq) begin
      idx = sAddr[3:0] & mMap[3:0];
      hit = mEn && mValid[idx] && (mAddr[idx] == sAddr);
      effL = (mLimit == 0) ? 1 : mLimit;
      expReady = hit ? (outN == 0) : (outN < effL);
      check(reqReady == expReady, hit ? "R11 hit held behind reads" : "R9 R12 miss acceptance",
            32'(reqReady), 32'(expReady));
      lastReady = reqReady;
      lastMiss = memReqValid;
      if (reqReady) begin
        check(memReqValid == !hit, !mEn ? "R4 bypass read" : (hit ? "R2 hit no read" : "R3 R12 miss read"),
              32'(memReqValid), 32'(!hit));
        if (memReqValid) check(memReqAddr == sAddr, "R3 read address", memReqAddr, sAddr);
        expQ.push_back(memWord(sAddr));
      end
    end
    if (memRspValid) begin
      logic [31:0] a;
      bit s;
      a = pendQ.pop_front();
      s = skipQ.pop_front();
      void'(dueQ.pop_front());
      if (!s) begin
        idx = a[3:0] & mMap[3:0];
        mValid[idx] = 1;
        mAddr[idx] = a;
      end
    end
    if (sReq && reqReady && memReqValid) begin
      pendQ.push_back(sAddr);
      skipQ.push_back(!mEn);
      dueQ.push_back(cyc + $urandom_range(latMax, latMin));
    end
    if (sFlWe) applyFlush(sFl);
    if (sHiWe) mHi = sHi;
    if (sCfgWe) begin
      mEn = sCfg[29];
      mLimit = int'(sCfg[27:24]);
      mMap = sCfg[5:0];
    end
    @(posedge clk);
  endtask

  task automatic clearStim();
    sReq = 0; sCfgWe = 0; sFlWe = 0; sHiWe = 0;
  endtask

  task automatic doReq(input logic [31:0] a);
    sReq = 1; sAddr = a; step(); clearStim();
  endtask

  task automatic doCfg(input logic en, input logic [3:0] lim, input logic [5:0] map);
    sCfgWe = 1; sCfg = cfgWord(en, lim, map); step(); clearStim();
  endtask

  task automatic doFlush(input logic [31:0] fw);
    sFlWe = 1; sFl = fw; step(); clearStim();
  endtask

  task automatic doHi(input logic [1:0] h);
    sHiWe = 1; sHi = h; step(); clearStim();
  endtask

  task automatic drain();
    int guard = 0;
    while ((pendQ.size() != 0 || expQ.size() != 0) && guard < 600) begin
      step();
      guard++;
    end
    step();
  endtask

  function automatic logic [31:0] randAddr();
    return {($urandom_range(1, 0) != 0) ? 2'b01 : 2'b00, 30'h80 + 30'($urandom_range(39, 0))};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < 16; i++) begin mValid[i] = 0; mAddr[i] = 0; end
    repeat (3) @(negedge clk);
    check(rspValid == 0, "R1 no response in reset", 32'(rspValid), 0);
    check(memReqValid == 0, "R1 no read in reset", 32'(memReqValid), 0);
    rstN = 1;
    step();

    // reset configuration bypasses; bypass reads fill nothing
    doReq(32'h0000_0100);
    check(lastMiss == 1, "R1 R4 request after reset reads memory", 32'(lastMiss), 1);
    drain();
    doCfg(1, 4'd8, 6'h3f);
    doReq(32'h0000_0100);
    check(lastMiss == 1, "R4 no fill while disabled", 32'(lastMiss), 1);
    drain();
    doReq(32'h0000_0100);
    check(lastReady && !lastMiss, "R2 R3 filled line hits", 32'(lastMiss), 0);
    drain();

    // flush by address with high bits
    latMin = 2; latMax = 4;
    doReq(32'h4000_0010);
    doReq(32'h4000_0018);
    drain();
    doHi(2'd0);
    doFlush(32'h0000_005D);
    doReq(32'h4000_0010);
    check(!lastMiss, "R7 high bits differ keeps line", 32'(lastMiss), 0);
    drain();
    doHi(2'd1);
    doFlush(32'h0000_005D);
    doReq(32'h4000_0010);
    check(lastMiss, "R6 aligned atom flushed", 32'(lastMiss), 1);
    drain();
    doReq(32'h4000_0018);
    check(!lastMiss, "R6 other atom kept", 32'(lastMiss), 0);
    drain();

    // flush all
    doReq(32'h0000_0100);
    drain();
    doFlush(32'h0000_0000);
    doReq(32'h0000_0100);
    check(lastMiss, "R5 flush all clears", 32'(lastMiss), 1);
    drain();
    doReq(32'h4000_0018);
    check(lastMiss, "R5 flush all clears second line", 32'(lastMiss), 1);
    drain();

    // flush while a fill is pending
    latMin = 6; latMax = 6;
    doReq(32'h0000_0222);
    step();
    doFlush(32'h0000_0000);
    drain();
    doReq(32'h0000_0222);
    check(lastMiss, "R10 flushed pending fill leaves no line", 32'(lastMiss), 1);
    drain();

    // read limit and its encoding
    latMin = 20; latMax = 20;
    doCfg(1, 4'd2, 6'h3f);
    doReq(32'h0000_0301);
    doReq(32'h0000_0302);
    doReq(32'h0000_0303);
    check(!lastReady, "R8 R9 third miss held at limit 2", 32'(lastReady), 0);
    drain();
    latMin = 10; latMax = 10;
    doCfg(1, 4'd0, 6'h3f);
    doReq(32'h0000_0311);
    doReq(32'h0000_0312);
    check(!lastReady, "R9 limit 0 acts as 1", 32'(lastReady), 0);
    drain();

    // hit behind outstanding read
    latMin = 5; latMax = 5;
    doCfg(1, 4'd8, 6'h3f);
    doReq(32'h0000_0311);
    doReq(32'h0000_0500);
    doReq(32'h0000_0311);
    check(!lastReady, "R11 hit held behind miss", 32'(lastReady), 0);
    drain();

    // index mask
    latMin = 1; latMax = 3;
    doCfg(1, 4'd8, 6'h00);
    doReq(32'h0000_0601); drain();
    doReq(32'h0000_0602); drain();
    doReq(32'h0000_0601);
    check(lastMiss, "R12 mask 0 aliases to one line", 32'(lastMiss), 1);
    drain();
    doCfg(1, 4'd8, 6'h3f);
    doReq(32'h0000_0601); drain();
    doReq(32'h0000_0602); drain();
    doReq(32'h0000_0601);
    check(!lastMiss, "R12 full mask separates lines", 32'(lastMiss), 0);
    drain();

    // constrained random
    latMin = 1; latMax = 8;
    for (int n = 0; n < 4000; n++) begin
      int r;
      logic [33:0] pa;
      r = $urandom_range(99, 0);
      sReq = ($urandom_range(9, 0) < 7);
      sAddr = randAddr();
      pa = {randAddr(), 2'b00};
      sFlWe = (r < 3);
      sFl = {pa[31:1], 1'($urandom_range(1, 0))};
      sHiWe = (r == 3 || r == 4);
      sHi = 2'($urandom_range(1, 0));
      sCfgWe = (r == 5);
      sCfg = cfgWord($urandom_range(9, 0) != 0, 4'($urandom_range(15, 0)),
                     ($urandom_range(3, 0) == 0) ? 6'($urandom_range(63, 0)) : 6'h3f);
      step();
      clearStim();
    end
    drain();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule